// File: doc/BRIEF.md
# Audio Fractional Clock Generator

This block derives the three clocks of an audio serial port from one fast reference clock. The master audio clock comes from a divider whose ratio has an integer part and a 16-bit fractional part. Each master-clock period lasts either the integer number of reference cycles or one cycle more. A phase accumulator decides which, so that over many periods the mean period matches the programmed ratio.

The bit clock is divided from the master clock and never taken straight from the reference. Every bit-clock edge therefore coincides with a master-clock rising edge. The word-select (frame) clock changes level on a bit-clock falling edge, once per programmed slot width. The master clock has its own enable, and the bit and frame clocks are driven only in master mode. Each of the two enables has a ready flag, which rises once two complete periods of its clock have been produced.

All outputs are registered in the reference-clock domain. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `audclk_gen`

## Requirements
- R1: `div_cfg[15:0]` is the integer ratio I and `div_cfg[31:16]` the fraction F. A 16-bit accumulator starts at zero on enable and adds F at the start of every master-clock period. That period lasts I+1 reference cycles when the addition carries out of 16 bits, and I cycles otherwise.
- R2: An integer ratio below 2 is treated as 2.
- R3: While `mclk_en` is low, `mclk` and `mclk_ready` are low on the next reference edge and stay low.
- R4: In master mode each half-period of `bclk` lasts `bclk_ratio`+1 master-clock periods. Every `bclk` edge falls on a cycle in which `mclk` rises.
- R5: In master mode `lrclk` changes level on the cycle of a `bclk` falling edge, once every `slot_width` bit-clock periods. A slot width of 0 acts as 1.
- R6: While `master_en` is low, `bclk`, `lrclk` and `bclk_ready` are low on the next reference edge and stay low. `mclk` keeps running.
- R7: `mclk_ready` rises on the cycle of the third `mclk` rising edge after enable, which is when two full periods are complete.
- R8: `bclk_ready` rises on the cycle of the second `bclk` falling edge after master mode is entered.
- R9: After reset all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | Runs the master-clock divider |
| master_en | input | 1 | Drives bit and frame clocks |
| div_cfg | input | 32 | Fraction [31:16], integer ratio [15:0] |
| bclk_ratio | input | 8 | Bit-clock half-period minus one, in master-clock periods |
| slot_width | input | 6 | Bit-clock periods per frame-clock level |
| mclk | output | 1 | Master audio clock |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (word-select) clock |
| mclk_ready | output | 1 | Master clock running stably |
| bclk_ready | output | 1 | Bit clock running |

## Verification
Setting or clearing an enable is visible on the outputs one reference rising edge later, because every output comes from a register. The ready flags, bit-clock edges and frame-clock changes all land in the same cycle as the clock edge that causes them, with no additional lag. Inputs are driven on falling edges and outputs are sampled on the next falling edge. Each flag is therefore compared exactly at the `mclk` rise or `bclk` fall it must coincide with, and the period lengths are measured as reference-cycle distances between sampled edges and compared with sums computed from the carry rule.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int ACG_INT_W   = 16;
  localparam int ACG_FRAC_W  = 16;
  localparam int ACG_RATIO_W = 8;
  localparam int ACG_SLOT_W  = 6;
  localparam int ACG_MIN_DIV = 2;
  localparam int ACG_RDY_PER = 2;
endpackage

// File: rtl/acg_frac_div.sv
module acg_frac_div #(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 16,
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              mclk_o,
  output logic              start_o,
  output logic              done_o
);
  localparam int CNT_W = INT_W + 1;
  localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_DIV);

  logic              run_q, run_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              mclk_q, mclk_d;
  logic [FRAC_W:0]   acc_sum;
  logic [INT_W-1:0]  int_eff;
  logic [CNT_W-1:0]  cnt_inc;
  logic              last;

  always_comb begin
    int_eff = (int_i < MIN_V) ? MIN_V : int_i;
    acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
    cnt_inc = cnt_q + CNT_W'(1);
    last    = run_q && (cnt_q == per_q - CNT_W'(1));
    start_o = en_i && (!run_q || last);
    done_o  = en_i && last;

    run_d  = run_q;
    cnt_d  = cnt_q;
    per_d  = per_q;
    acc_d  = acc_q;
    mclk_d = mclk_q;
    if (!en_i) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      per_d  = '0;
      acc_d  = '0;
      mclk_d = 1'b0;
    end else if (start_o) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      per_d  = {1'b0, int_eff} + CNT_W'(acc_sum[FRAC_W]);
      acc_d  = acc_sum[FRAC_W-1:0];
      mclk_d = 1'b1;
    end else begin
      cnt_d  = cnt_inc;
      mclk_d = (cnt_inc < (per_q >> 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      acc_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      acc_q  <= acc_d;
      mclk_q <= mclk_d;
    end
  end

  assign mclk_o = mclk_q;
endmodule

// File: rtl/acg_bclk_div.sv
module acg_bclk_div #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               bclk_o,
  output logic               fall_o
);
  logic [RATIO_W-1:0] hcnt_q, hcnt_d;
  logic               bclk_q, bclk_d;
  logic               hit;

  always_comb begin
    hit    = tick_i && (hcnt_q >= ratio_i);
    fall_o = en_i && hit && bclk_q;
    hcnt_d = hcnt_q;
    bclk_d = bclk_q;
    if (!en_i) begin
      hcnt_d = '0;
      bclk_d = 1'b0;
    end else if (hit) begin
      hcnt_d = '0;
      bclk_d = ~bclk_q;
    end else if (tick_i) begin
      hcnt_d = hcnt_q + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      bclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;
endmodule

// File: rtl/acg_lrclk_gen.sv
module acg_lrclk_gen #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              fall_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              lrclk_o
);
  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              lr_q, lr_d;
  logic [SLOT_W-1:0] slot_eff;
  logic [SLOT_W:0]   cnt_inc;

  always_comb begin
    slot_eff = (slot_i == '0) ? SLOT_W'(1) : slot_i;
    cnt_inc  = {1'b0, cnt_q} + (SLOT_W+1)'(1);
    cnt_d    = cnt_q;
    lr_d     = lr_q;
    if (!en_i) begin
      cnt_d = '0;
      lr_d  = 1'b0;
    end else if (fall_i) begin
      if (cnt_inc >= {1'b0, slot_eff}) begin
        cnt_d = '0;
        lr_d  = ~lr_q;
      end else begin
        cnt_d = cnt_inc[SLOT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lr_q  <= lr_d;
    end
  end

  assign lrclk_o = lr_q;
endmodule

// File: rtl/acg_ready_mon.sv
module acg_ready_mon #(
  parameter int NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic done_i,
  output logic ready_o
);
  localparam int CW = (NEED < 2) ? 1 : $clog2(NEED + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!en_i) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (done_i && !rdy_q) begin
      if (cnt_q == CW'(NEED - 1)) rdy_d = 1'b1;
      else                        cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import acg_pkg::*;
#(
  parameter int INT_W   = ACG_INT_W,
  parameter int FRAC_W  = ACG_FRAC_W,
  parameter int RATIO_W = ACG_RATIO_W,
  parameter int SLOT_W  = ACG_SLOT_W
) (
  input  logic                      clk_ref,
  input  logic                      rst_n,
  input  logic                      mclk_en,
  input  logic                      master_en,
  input  logic [INT_W+FRAC_W-1:0]   div_cfg,
  input  logic [RATIO_W-1:0]        bclk_ratio,
  input  logic [SLOT_W-1:0]         slot_width,
  output logic                      mclk,
  output logic                      bclk,
  output logic                      lrclk,
  output logic                      mclk_ready,
  output logic                      bclk_ready
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       per_start, per_done, bclk_fall;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acg_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_DIV(ACG_MIN_DIV)) u_mdiv (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .en_i    (mclk_en),
    .int_i   (div_cfg[INT_W-1:0]),
    .frac_i  (div_cfg[INT_W+FRAC_W-1:INT_W]),
    .mclk_o  (mclk),
    .start_o (per_start),
    .done_o  (per_done)
  );

  acg_bclk_div #(.RATIO_W(RATIO_W)) u_bdiv (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .en_i    (master_en),
    .tick_i  (per_start),
    .ratio_i (bclk_ratio),
    .bclk_o  (bclk),
    .fall_o  (bclk_fall)
  );

  acg_lrclk_gen #(.SLOT_W(SLOT_W)) u_lr (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .en_i    (master_en),
    .fall_i  (bclk_fall),
    .slot_i  (slot_width),
    .lrclk_o (lrclk)
  );

  acg_ready_mon #(.NEED(ACG_RDY_PER)) u_mrdy (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .en_i    (mclk_en),
    .done_i  (per_done),
    .ready_o (mclk_ready)
  );

  acg_ready_mon #(.NEED(ACG_RDY_PER)) u_brdy (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .en_i    (master_en),
    .done_i  (bclk_fall),
    .ready_o (bclk_ready)
  );
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic mclk_en,
  input logic master_en,
  input logic mclk,
  input logic bclk,
  input logic lrclk,
  input logic mclk_ready,
  input logic bclk_ready
);
  p_mclk_idle_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !mclk_en |=> (!mclk && !mclk_ready));

  p_bclk_idle_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !master_en |=> (!bclk && !lrclk && !bclk_ready));

  p_bclk_on_mclk_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(master_en) && !$stable(bclk)) |-> $rose(mclk));

  p_lr_on_bfall_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(master_en) && !$stable(lrclk)) |-> $fell(bclk));

  p_mrdy_on_rise_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(mclk_ready) |-> $rose(mclk));

  p_brdy_on_fall_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(bclk_ready) |-> $fell(bclk));
endmodule

bind audclk_gen audclk_gen_chk u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .mclk_en    (mclk_en),
  .master_en  (master_en),
  .mclk       (mclk),
  .bclk       (bclk),
  .lrclk      (lrclk),
  .mclk_ready (mclk_ready),
  .bclk_ready (bclk_ready)
);

// File: tb/audclk_gen_tb.sv
module audclk_gen_tb;
  // one time unit = 1 ns; 4-unit period gives the 250 MHz reference clock
  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        mclk_en, master_en;
  logic [31:0] div_cfg;
  logic [7:0]  bclk_ratio;
  logic [5:0]  slot_width;
  logic        mclk, bclk, lrclk, mclk_ready, bclk_ready;

  int checks = 0;
  int fails  = 0;
  bit fin    = 0;

  always #2 clk_ref = ~clk_ref;

  audclk_gen u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .mclk_en(mclk_en), .master_en(master_en),
    .div_cfg(div_cfg), .bclk_ratio(bclk_ratio), .slot_width(slot_width),
    .mclk(mclk), .bclk(bclk), .lrclk(lrclk),
    .mclk_ready(mclk_ready), .bclk_ready(bclk_ready)
  );

  // integer, fraction, bclk ratio, slot width,
  // expected sum of first 8 mclk periods, expected bclk half (mclk periods),
  // expected bclk falls per lrclk level
  typedef struct packed {
    int iv; int fv; int rv; int sv; int esum; int ebh; int esl;
  } vec_t;
  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{4, 0,      1, 2, 32, 2, 2},
    '{3, 'h8000, 0, 3, 28, 1, 3},
    '{5, 'h4000, 2, 1, 42, 3, 1},
    '{1, 0,      3, 4, 16, 4, 4},
    '{2, 'hC000, 1, 0, 22, 2, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mclk_en = 1'b0; master_en = 1'b0;
    div_cfg = '0; bclk_ratio = '0; slot_width = '0;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_ref);
    // R9: reset state
    chk({mclk, bclk, lrclk, mclk_ready, bclk_ready} == 5'b0, "R9 reset outputs",
        int'({mclk, bclk, lrclk, mclk_ready, bclk_ready}), 0);

    for (int v = 0; v < NVEC; v++) begin
      int cyc, mr, bf, t1, t9, bh, lc, lr_st;
      bit bh_st, bh_done, misalign;
      logic pm, pb, pl;
      @(negedge clk_ref);
      mclk_en = 1'b0; master_en = 1'b0;
      @(negedge clk_ref);
      div_cfg    = {16'(VEC[v].fv), 16'(VEC[v].iv)};
      bclk_ratio = 8'(VEC[v].rv);
      slot_width = 6'(VEC[v].sv);
      mclk_en = 1'b1; master_en = 1'b1;
      pm = mclk; pb = bclk; pl = lrclk;
      cyc = 0; mr = 0; bf = 0; t1 = 0; t9 = 0; bh = 0; lc = 0; lr_st = 0;
      bh_st = 0; bh_done = 0; misalign = 0;
      while (cyc < 5000 && !(mr >= 9 && bf >= 2 && bh_done && lr_st == 2)) begin
        bit rm, rb, fb, tl;
        @(negedge clk_ref);
        cyc++;
        rm = mclk && !pm; rb = bclk && !pb; fb = !bclk && pb; tl = (lrclk != pl);
        if ((rb || fb) && !rm) misalign = 1;
        if (rm) begin
          mr++;
          if (mr == 1) t1 = cyc;
          if (mr == 9) t9 = cyc;
          if (mr == 2) chk(mclk_ready == 1'b0, "R7 ready low at 2nd mclk rise", int'(mclk_ready), 0);
          if (mr == 3) chk(mclk_ready == 1'b1, "R7 ready high at 3rd mclk rise", int'(mclk_ready), 1);
        end
        if (fb) begin
          bf++;
          if (bf == 1) chk(bclk_ready == 1'b0, "R8 ready low at 1st bclk fall", int'(bclk_ready), 0);
          if (bf == 2) chk(bclk_ready == 1'b1, "R8 ready high at 2nd bclk fall", int'(bclk_ready), 1);
        end
        if (bh_st && !bh_done) begin
          if (rm) bh++;
          if (fb) begin
            bh_done = 1;
            chk(bh == VEC[v].ebh, "R4 bclk half-period", bh, VEC[v].ebh);
          end
        end else if (rb && !bh_st) begin
          bh_st = 1; bh = 0;
        end
        if (lr_st == 1) begin
          if (fb) lc++;
          if (tl) begin
            lr_st = 2;
            chk(lc == VEC[v].esl, "R5 bclk periods per lrclk level", lc, VEC[v].esl);
          end
        end else if (lr_st == 0 && tl) begin
          lr_st = 1; lc = 0;
        end
        pm = mclk; pb = bclk; pl = lrclk;
      end
      // R1 / R2: period sum from accumulator carry rule (entry 3 uses clamp)
      chk(t9 - t1 == VEC[v].esum, (VEC[v].iv < 2) ? "R2 clamped period sum" : "R1 mclk period sum",
          t9 - t1, VEC[v].esum);
      chk(!misalign, "R4 bclk edge on mclk rise", int'(misalign), 0);
    end

    // R6: master off while mclk runs
    @(negedge clk_ref);
    master_en = 1'b0;
    @(negedge clk_ref);
    chk({bclk, lrclk, bclk_ready} == 3'b0, "R6 master off next edge",
        int'({bclk, lrclk, bclk_ready}), 0);
    begin
      int hi, rises;
      logic pm2;
      hi = 0; rises = 0; pm2 = mclk;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_ref);
        if (bclk || lrclk || bclk_ready) hi++;
        if (mclk && !pm2) rises++;
        pm2 = mclk;
      end
      chk(hi == 0, "R6 bclk/lrclk held low", hi, 0);
      chk(rises > 0, "R6 mclk keeps running", rises, 1);
    end

    // R3: mclk disable
    mclk_en = 1'b0;
    @(negedge clk_ref);
    chk({mclk, mclk_ready} == 2'b0, "R3 mclk off next edge", int'({mclk, mclk_ready}), 0);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_ref);
        if (mclk || mclk_ready) hi++;
      end
      chk(hi == 0, "R3 mclk held low", hi, 0);
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule